// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block collects 32 interrupt request lines and delivers them to a grid of sixteen output interrupt lines. Each output stands for one pair of a target core (four of them) and a parent interrupt input of that core (four of them). Every source is first passed through a two-flop synchroniser. It is then conditioned as either a level request or an edge request, and the active sense is programmable. The conditioned request is gated by a per-source enable and steered by a routing byte that belongs to that source.

Software programs the block through a simple request bus. A request is offered on `req_valid` and is taken in the same cycle. A byte write programs a routing byte. Word writes program the enable, polarity and edge controls and clear captured edges. Read data comes back exactly one cycle after the request, marked by `rd_valid`.

The bus side is a two-state machine:
- **BUS_IDLE**: no read is in flight.
- **BUS_RESP**: read data is being presented.

The transitions are:
- **issue_read**: a read request moves the machine to BUS_RESP. A read request that arrives while in BUS_RESP keeps it there.
- **resp_done**: without a read request, the machine returns to BUS_IDLE.

Top module: `rirq_ctrl`

## Requirements
- R1: After reset every enable, edge bit and routing byte is 0 and every polarity bit is 1. Reads of offsets 0x24, 0x34, 0x30, 0x40 return 0, 0, 0xFFFFFFFF, 0, and `irq_o` is all zero.
- R2: A byte write to offset N (0x00 to 0x1F) stores `req_wdata[7:0]` as the routing byte of source N. Bits 7:4 select parents 3..0 and bits 3:0 select cores 3..0. A read of offset N returns that byte in `rd_data[7:0]`.
- R3: A word write to 0x28 sets the enable of every source whose data bit is 1 and leaves the enables of all other sources unchanged.
- R4: A word write to 0x2C clears the enable of every source whose data bit is 1. The enable vector reads back at 0x24.
- R5: Polarity (0x30) and edge (0x34) are readable word registers. With edge=0, a source is asserted while its input equals its polarity bit (1 = active high, 0 = active low).
- R6: With edge=1, a selected edge of the synchronised input sets a sticky latch: rising when pol=1, falling when pol=0. The latch holds until a word write to 0x40 has a 1 in that bit. Writing 0 bits to 0x40 leaves the latches unchanged.
- R7: A read of 0x40 returns, per source, asserted AND enabled. A disabled source reads 0 even while it is asserted.
- R8: `irq_o[c*4+p]` is the OR of every pending source whose routing byte has core bit c and parent bit (4+p) set. A routing byte with no core bit or no parent bit set drives no output.
- R9: In level mode an input change reaches `irq_o` after exactly two rising clock edges, and not after one.
- R10: `rd_valid` is high in the cycle after each read request and low otherwise. Unmapped offsets read as 0.
- R11: Word writes into the routing region and byte writes to control offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Asynchronous interrupt source lines |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data (byte writes use bits 7:0) |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 32 | Read data |
| irq_o | output | 16 | Output lines, index core*4+parent |

## Verification
Random level-mode rounds mix random polarities, enable set/clear pairs, routing bytes (including bytes with no core or no parent bit, and bytes with several bits set) and input vectors. These rounds separate polarity handling, enable gating and the OR across the routing matrix, since several sources routed to one line must merge and unrouted ones must vanish. Directed edge cases drive a falling edge, then the opposite edge, then a clear with zero data and a clear with the matching bit. These show that the latch is sticky, that only the selected edge sets it, and that a clear acts only on its own bit. A single-step input change, observed after one edge and again after two, pins down the synchroniser latency. Misdirected byte and word writes show that accesses of the wrong size are ignored.

// File: rtl/rirq_pkg.sv
package rirq_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] OFF_EN_RD  = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_EN_SET = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_EN_CLR = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_POL    = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_EDGE   = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h40;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;
endpackage

// File: rtl/rirq_sync.sv
module rirq_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_o = sync_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/rirq_cell.sv
module rirq_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic cur_i,
    input  logic prev_i,
    input  logic edge_i,
    input  logic pol_i,
    input  logic clr_i,
    output logic act_o
);
    logic lat_q;
    logic lvl;
    logic hit;

    always_comb begin
        lvl = pol_i ? cur_i : ~cur_i;
        hit = pol_i ? (cur_i & ~prev_i) : (~cur_i & prev_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      lat_q <= 1'b0;
        else if (edge_i) lat_q <= hit | (lat_q & ~clr_i);
        else             lat_q <= 1'b0;
    end

    assign act_o = edge_i ? lat_q : lvl;

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && lat_q && !clr_i) |=> lat_q);
endmodule

// File: rtl/rirq_route.sv
module rirq_route #(
    parameter int NUM_SRC  = 32,
    parameter int NUM_CORE = 4,
    parameter int NUM_PAR  = 4,
    localparam int ROUTE_W = NUM_CORE + NUM_PAR
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_SRC-1:0]                 pend_i,
    input  logic [NUM_SRC-1:0][ROUTE_W-1:0]    route_i,
    output logic [NUM_CORE*NUM_PAR-1:0]        irq_o
);
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        for (genvar p = 0; p < NUM_PAR; p++) begin : g_par
            logic [NUM_SRC-1:0] hits;
            always_comb begin
                for (int s = 0; s < NUM_SRC; s++) begin
                    hits[s] = pend_i[s] & route_i[s][c] & route_i[s][NUM_CORE+p];
                end
            end
            assign irq_o[c*NUM_PAR+p] = |hits;
        end
    end

    // R8
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |-> (irq_o == '0));
endmodule

// File: rtl/rirq_ctrl.sv
module rirq_ctrl
    import rirq_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_CORE = 4,
    parameter int NUM_PAR  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SRC-1:0]           src_i,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic                         req_byte,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [DATA_W-1:0]            req_wdata,
    output logic                         rd_valid,
    output logic [DATA_W-1:0]            rd_data,
    output logic [NUM_CORE*NUM_PAR-1:0]  irq_o
);
    localparam int ROUTE_W = NUM_CORE + NUM_PAR;
    localparam int SRC_IW  = $clog2(NUM_SRC);

    bus_state_e state_q, state_d;

    logic [NUM_SRC-1:0]              en_q, pol_q, edge_q;
    logic [NUM_SRC-1:0][ROUTE_W-1:0] route_q;
    logic [NUM_SRC-1:0]              cur, prev, act, pend, clr;
    logic [DATA_W-1:0]               rd_mux, rd_q;
    logic                            wr_word, wr_byte, rd_req, in_route;
    logic [SRC_IW-1:0]               idx;

    assign wr_word  = req_valid & req_write & ~req_byte;
    assign wr_byte  = req_valid & req_write & req_byte;
    assign rd_req   = req_valid & ~req_write;
    assign in_route = int'(req_addr) < NUM_SRC;
    assign idx      = req_addr[SRC_IW-1:0];
    assign clr      = (wr_word && req_addr == OFF_STAT) ? req_wdata[NUM_SRC-1:0] : '0;

    rirq_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(src_i), .sync_o(cur), .prev_o(prev)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        rirq_cell u_cell (
            .clk(clk), .rst_n(rst_n), .cur_i(cur[s]), .prev_i(prev[s]),
            .edge_i(edge_q[s]), .pol_i(pol_q[s]), .clr_i(clr[s]), .act_o(act[s])
        );
    end

    assign pend = act & en_q;

    rirq_route #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PAR(NUM_PAR)) u_route (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .route_i(route_q), .irq_o(irq_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            pol_q   <= '1;
            edge_q  <= '0;
            route_q <= '0;
        end else begin
            if (wr_byte && in_route) route_q[idx] <= req_wdata[ROUTE_W-1:0];
            if (wr_word) begin
                unique case (req_addr)
                    OFF_EN_SET: en_q   <= en_q | req_wdata[NUM_SRC-1:0];
                    OFF_EN_CLR: en_q   <= en_q & ~req_wdata[NUM_SRC-1:0];
                    OFF_POL:    pol_q  <= req_wdata[NUM_SRC-1:0];
                    OFF_EDGE:   edge_q <= req_wdata[NUM_SRC-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (in_route) begin
            rd_mux[ROUTE_W-1:0] = route_q[idx];
        end else begin
            unique case (req_addr)
                OFF_EN_RD: rd_mux[NUM_SRC-1:0] = en_q;
                OFF_POL:   rd_mux[NUM_SRC-1:0] = pol_q;
                OFF_EDGE:  rd_mux[NUM_SRC-1:0] = edge_q;
                OFF_STAT:  rd_mux[NUM_SRC-1:0] = pend;
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req) rd_q <= rd_mux;
        end
    end

    // next state
    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_valid = (state_q == BUS_RESP);
        rd_data  = rd_valid ? rd_q : '0;
    end

    // R3
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_word && req_addr == OFF_EN_SET) |=>
        ((en_q & $past(req_wdata[NUM_SRC-1:0])) == $past(req_wdata[NUM_SRC-1:0])));
    // R4
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_word && req_addr == OFF_EN_CLR) |=>
        ((en_q & $past(req_wdata[NUM_SRC-1:0])) == '0));
    // R10
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    // R10
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
    // R11
    route_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_word && in_route) |=> (route_q == $past(route_q)));
endmodule

// File: tb/rirq_ctrl_bench.sv
module rirq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_r = '0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [15:0] irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_en, m_pol;
    logic [7:0]  m_route [32];

    always #5 clk = ~clk;

    rirq_ctrl u_rirq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(src_r),
        .req_valid(req_valid), .req_write(req_write), .req_byte(req_byte),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(bit byte_acc, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_byte = byte_acc; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0; req_byte = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_byte = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        d = rd_valid ? rd_data : 32'hDEAD_BEEF;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_irq(logic [31:0] pend);
        logic [15:0] r = '0;
        for (int s = 0; s < 32; s++)
            for (int c = 0; c < 4; c++)
                for (int p = 0; p < 4; p++)
                    if (pend[s] && m_route[s][c] && m_route[s][4+p]) r[c*4+p] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] lvl_pend(logic [31:0] src);
        return m_en & ~(src ^ m_pol);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, a, b;
        void'($urandom(32'd2024));
        m_en = '0; m_pol = '1;
        for (int i = 0; i < 32; i++) m_route[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        check("R1 irq", {16'h0, irq_o}, 32'h0);
        rd(8'h24, d); check("R1 enable", d, 32'h0);
        rd(8'h34, d); check("R1 edge", d, 32'h0);
        rd(8'h30, d); check("R1 polarity", d, 32'hFFFF_FFFF);
        rd(8'h40, d); check("R1 status", d, 32'h0);
        rd(8'h00, d); check("R1 route", d, 32'h0);

        // R9 synchroniser latency: source 5 -> core0/parent0
        wr(1, 8'h05, 32'h11); m_route[5] = 8'h11;
        rd(8'h05, d); check("R2 route readback", d, 32'h11);
        wr(0, 8'h28, 32'h20); m_en = 32'h20;
        rd(8'h24, d); check("R3 enable set", d, 32'h20);
        settle();
        @(negedge clk); src_r[5] = 1;
        @(negedge clk); check("R9 after one edge", {31'h0, irq_o[0]}, 32'h0);
        @(negedge clk); check("R9 after two edges", {31'h0, irq_o[0]}, 32'h1);

        // random level-mode rounds (R5 R7 R8 R3 R4)
        for (int it = 0; it < 40; it++) begin
            m_pol = $urandom; wr(0, 8'h30, m_pol);
            a = $urandom; b = $urandom & $urandom;
            wr(0, 8'h28, a); wr(0, 8'h2C, b); m_en = (m_en | a) & ~b;
            for (int k = 0; k < 3; k++) begin
                int s = $urandom % 32;
                m_route[s] = 8'($urandom);
                wr(1, 8'(s), {24'h0, m_route[s]});
            end
            src_r = $urandom;
            settle();
            check("R8 matrix", {16'h0, irq_o}, {16'h0, exp_irq(lvl_pend(src_r))});
            rd(8'h40, d); check("R7 status", d, lvl_pend(src_r));
            rd(8'h24, d); check("R4 enable readback", d, m_en);
        end

        // R8 empty routing bytes drive nothing
        wr(0, 8'h2C, 32'hFFFF_FFFF); m_en = '0;
        rd(8'h24, d); check("R4 disable all", d, 32'h0);
        src_r = '0; m_pol = '1; wr(0, 8'h30, m_pol);
        wr(1, 8'h09, 32'h0F); wr(1, 8'h0A, 32'hF0);
        m_route[9] = 8'h0F; m_route[10] = 8'hF0;
        wr(0, 8'h28, 32'h600); m_en = 32'h600;
        src_r[9] = 1; src_r[10] = 1; settle();
        check("R8 no-parent/no-core", {16'h0, irq_o}, 32'h0);
        rd(8'h40, d); check("R7 pending unrouted", d, 32'h600);
        wr(0, 8'h2C, 32'h600); m_en = '0;
        rd(8'h40, d); check("R7 disabled hidden", d, 32'h0);
        src_r = '0;

        // R5 active-low level
        wr(1, 8'h03, 32'h44); m_route[3] = 8'h44;
        wr(0, 8'h30, 32'hFFFF_FFF7); wr(0, 8'h28, 32'h8);
        settle();
        check("R5 active low asserted", {31'h0, irq_o[2*4+2]}, 32'h1);
        src_r[3] = 1; settle();
        check("R5 active low released", {31'h0, irq_o[2*4+2]}, 32'h0);
        wr(0, 8'h2C, 32'h8); wr(0, 8'h30, 32'hFFFF_FFFF);

        // R6 falling edge on source 7 -> core1/parent3
        wr(1, 8'h07, 32'h82);
        src_r[7] = 1; settle();
        wr(0, 8'h30, 32'hFFFF_FF7F); wr(0, 8'h34, 32'h80); wr(0, 8'h28, 32'h80);
        settle();
        check("R6 no edge yet", {31'h0, irq_o[7]}, 32'h0);
        src_r[7] = 0; settle();
        check("R6 falling captured", {31'h0, irq_o[7]}, 32'h1);
        src_r[7] = 1; settle();
        check("R6 sticky", {31'h0, irq_o[7]}, 32'h1);
        wr(0, 8'h40, 32'h0); settle();
        check("R6 zero clear ignored", {31'h0, irq_o[7]}, 32'h1);
        wr(0, 8'h40, 32'h80); settle();
        check("R6 cleared", {31'h0, irq_o[7]}, 32'h0);
        rd(8'h34, d); check("R5 edge readback", d, 32'h80);
        // rising mode
        wr(0, 8'h30, 32'hFFFF_FFFF);
        src_r[7] = 0; settle();
        check("R6 falling ignored in rising", {31'h0, irq_o[7]}, 32'h0);
        src_r[7] = 1; settle();
        check("R6 rising captured", {31'h0, irq_o[7]}, 32'h1);
        rd(8'h40, d); check("R7 edge status", d, 32'h80);

        // R11 wrong-size writes
        wr(1, 8'h30, 32'h0000_0012);
        rd(8'h30, d); check("R11 byte to control ignored", d, 32'hFFFF_FFFF);
        wr(0, 8'h07, 32'h0000_0033);
        rd(8'h07, d); check("R11 word to route ignored", d, 32'h82);

        // R10 unmapped read and rd_valid drop
        rd(8'h50, d); check("R10 unmapped", d, 32'h0);
        @(negedge clk); check("R10 rd_valid low", {31'h0, rd_valid}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule